// File: doc/BRIEF.md
# Configuration Load and CRC Check Sequencer

This block is the device-side controller that brings configuration memory up from power-on. When reset is released, or after a low pulse on the program input, it sweeps the configuration memory clear. During the sweep it pulls the shared open-drain INIT line low. When the sweep ends it lets go of INIT. If something outside still holds the line low, the block waits until it reads the line high before it accepts any bitstream bits.

Bits arrive serially, one for each clock on which the valid input is high. The first 32 bits are a length word that says how many payload bits follow. A 16-bit check value comes after the payload. A CRC-16 runs over the length word and the payload. At the end of the stream the block compares the running CRC with the received check value:

- **Mismatch:** the block pulls INIT low again, so INIT now reports an error. DONE stays low. This error state holds until the program input is pulsed low.
- **Match:** the block runs a four-phase start-up. DONE rises in the last phase, and a one-clock release strobe for user logic follows in the next clock.

Top module: `cfg_load_seq`

## Requirements
- R1: While reset is asserted, `init_low` is 1, and `done` and `user_release` are 0.
- R2: After reset is released with `prog_n` high, `init_low` stays 1 for exactly CLEAR_CYCLES rising edges and is then 0.
- R3: While `prog_n` is low at a rising edge, the block returns to clearing. This applies in every state, including during a clear. The full CLEAR_CYCLES count then restarts from the first edge at which `prog_n` is high again.
- R4: After the clear, while the sensed INIT line `init_in` is low, the block keeps waiting. Bits offered on `cfg_bit`/`cfg_valid` are ignored, and the next load after release behaves as though they were never sent.
- R5: A bit is taken only on a rising edge with `cfg_valid` high. The stream is sent most significant bit first and has three parts, in this order:
  - a 32-bit length L;
  - L payload bits;
  - a 16-bit expected CRC.
- R6: The CRC uses polynomial 0x8005 (x^16+x^15+x^2+1). It is cleared to 0 at each load and is updated serially by each length and payload bit: the feedback is crc[15] XOR bit, then the register shifts left and XORs 0x8005 when the feedback is 1. The expected-CRC bits are not included.
- R7: On a CRC match, `done` is 0 for the three edges after the edge that takes the last CRC bit. It becomes 1 after the fourth edge and then stays 1.
- R8: `user_release` is high for exactly one clock, in the clock after the first clock with `done` high.
- R9: On a CRC mismatch, `init_low` becomes 1 after the edge that takes the last CRC bit. `done` stays 0. Both hold while more bits are offered, until `prog_n` goes low.
- R10: A length of 0 goes straight from the length word to the 16 CRC bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| prog_n | input | 1 | Program request, active low; a low pulse restarts configuration |
| init_in | input | 1 | Sensed level of the shared INIT line |
| cfg_valid | input | 1 | Configuration bit valid this clock |
| cfg_bit | input | 1 | Serial configuration bit |
| init_low | output | 1 | Pull INIT low (clearing or CRC error) |
| done | output | 1 | Configuration complete |
| user_release | output | 1 | One-clock strobe that releases user logic |

## Verification
The bench builds the block with CLEAR_CYCLES set to 8. This makes the exact clear length, and restarts of the clear part-way through, cheap to measure edge by edge. Random stream lengths of 0 to 63 payload bits, with random idle gaps on `cfg_valid`, reach both the zero-length path and long payloads within a short run. Good and corrupted check values are mixed in, so each load ends in either the start-up sequence or the sticky error state.

// File: rtl/cfg_load_seq.sv
module cfg_load_seq #(
  parameter int CLEAR_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  input  logic init_in,
  input  logic cfg_valid,
  input  logic cfg_bit,
  output logic init_low,
  output logic done,
  output logic user_release
);
  localparam logic [31:0] CLR_LAST = 32'(CLEAR_CYCLES - 1);
  localparam logic [15:0] POLY = 16'h8005;

  typedef enum logic [3:0] {S_CLR, S_WAIT, S_HDR, S_DATA, S_CRC, S_UP, S_REL, S_DONE, S_ERR} st_t;

  st_t         state;
  logic [31:0] cnt, len;
  logic [15:0] crc, rx;
  logic [1:0]  ph;

  wire [15:0] crc_nxt = {crc[14:0], 1'b0} ^ ({16{crc[15] ^ cfg_bit}} & POLY);
  wire [31:0] len_nxt = {len[30:0], cfg_bit};
  wire [15:0] rx_nxt  = {rx[14:0], cfg_bit};

  assign init_low     = (state == S_CLR) || (state == S_ERR);
  assign done         = (state == S_UP && ph == 2'd3) || state == S_REL || state == S_DONE;
  assign user_release = (state == S_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_CLR;
      cnt <= '0; len <= '0; crc <= '0; rx <= '0; ph <= '0;
    end else if (!prog_n) begin
      state <= S_CLR;
      cnt <= '0;
    end else begin
      unique case (state)
        S_CLR:
          if (cnt == CLR_LAST) begin state <= S_WAIT; cnt <= '0; end
          else cnt <= cnt + 32'd1;
        S_WAIT:
          if (init_in) begin state <= S_HDR; crc <= '0; cnt <= '0; end
        S_HDR:
          if (cfg_valid) begin
            len <= len_nxt;
            crc <= crc_nxt;
            if (cnt == 32'd31) begin
              cnt <= '0;
              state <= (len_nxt == '0) ? S_CRC : S_DATA;
            end else cnt <= cnt + 32'd1;
          end
        S_DATA:
          if (cfg_valid) begin
            crc <= crc_nxt;
            if (cnt == len - 32'd1) begin cnt <= '0; state <= S_CRC; end
            else cnt <= cnt + 32'd1;
          end
        S_CRC:
          if (cfg_valid) begin
            rx <= rx_nxt;
            if (cnt == 32'd15) begin
              cnt <= '0;
              ph <= '0;
              state <= (rx_nxt == crc) ? S_UP : S_ERR;
            end else cnt <= cnt + 32'd1;
          end
        S_UP: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) state <= S_REL;
        end
        S_REL:  state <= S_DONE;
        default: state <= state;
      endcase
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |-> init_low && !done && !user_release); // R1
  AST_CLR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) state == S_CLR |-> cnt <= CLR_LAST); // R2
  AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !prog_n |=> init_low && !done); // R3
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state == S_WAIT && !init_in && prog_n) |=> state == S_WAIT); // R4
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) done |-> !init_low); // R7
  AST_REL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) user_release |-> $past(done) && !$past(user_release)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (state == S_ERR && prog_n) |=> state == S_ERR && !done); // R9
endmodule

// File: tb/tb_cfg_load_seq.sv
module tb_cfg_load_seq;
  localparam int NCLR = 8;
  logic clk = 0, rst_n = 0, prog_n = 1, ext_hold = 0, cfg_valid = 0, cfg_bit = 0;
  logic init_low, done, user_release;
  wire init_in = ~(init_low | ext_hold);
  int checks = 0, errors = 0, cycles = 0;
  logic sb [0:143];
  int nbits;

  always #2 clk = ~clk;

  cfg_load_seq #(.CLEAR_CYCLES(NCLR)) dut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .init_in(init_in),
    .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .init_low(init_low), .done(done), .user_release(user_release));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic fb = c[15] ^ sb[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
    end
    return c;
  endfunction

  task automatic build(input int len, input bit good);
    logic [15:0] c;
    for (int i = 0; i < 32; i++) sb[i] = len[31-i];
    for (int i = 0; i < len; i++) sb[32+i] = 1'($urandom);
    c = crc_of(32 + len);
    if (!good) c = c ^ 16'(1 << ($urandom % 16));
    for (int i = 0; i < 16; i++) sb[32+len+i] = c[15-i];
    nbits = 48 + len;
  endtask

  task automatic send_stream();
    for (int i = 0; i < nbits; i++) begin
      if ($urandom % 4 == 0) begin cfg_valid = 0; @(negedge clk); end
      cfg_valid = 1; cfg_bit = sb[i];
      @(negedge clk);
    end
    cfg_valid = 0;
  endtask

  task automatic measure_clear(input string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (init_low && n < 100);
    chk(n == NCLR, req, n, NCLR);
  endtask

  task automatic restart();
    prog_n = 0; @(negedge clk);
    chk(init_low && !done, "R3", {init_low, done}, 2);
    prog_n = 1;
    measure_clear("R3");
    @(negedge clk);
  endtask

  task automatic expect_good(input string req);
    for (int k = 1; k <= 3; k++) begin
      chk(!done, "R7", done, 0);
      @(negedge clk);
    end
    chk(done, req, done, 1);
    chk(!user_release, "R8", user_release, 0);
    @(negedge clk);
    chk(user_release && done, "R8", user_release, 1);
    @(negedge clk);
    chk(!user_release && done, "R8", user_release, 0);
  endtask

  task automatic expect_bad();
    chk(init_low && !done, "R9", {init_low, done}, 2);
    for (int i = 0; i < 20; i++) begin
      cfg_valid = 1; cfg_bit = 1'($urandom);
      @(negedge clk);
    end
    cfg_valid = 0;
    chk(init_low && !done, "R9", {init_low, done}, 2);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL R1..: watchdog expired, actual %0d expected <100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(init_low && !done && !user_release, "R1", {init_low, done, user_release}, 4);
    rst_n = 1;
    measure_clear("R2");
    @(negedge clk);
    build(0, 1); send_stream(); expect_good("R10");
    prog_n = 0; @(negedge clk); prog_n = 1;
    repeat (4) @(negedge clk);
    prog_n = 0; @(negedge clk); prog_n = 1;
    measure_clear("R3");
    restart();
    build(0, 0); send_stream(); expect_bad();
    prog_n = 0; @(negedge clk); prog_n = 1;
    ext_hold = 1;
    repeat (NCLR + 2) @(negedge clk);
    chk(!init_low, "R4", init_low, 0);
    for (int i = 0; i < 40; i++) begin
      cfg_valid = 1; cfg_bit = 1'($urandom); @(negedge clk);
    end
    cfg_valid = 0;
    chk(!done && !init_low, "R4", done, 0);
    ext_hold = 0; @(negedge clk);
    build(17, 1); send_stream(); expect_good("R4");
    for (int it = 0; it < 14; it++) begin
      int len = int'($urandom % 64);
      bit good = ($urandom % 3) != 0;
      restart();
      build(len, good); send_stream();
      if (good) expect_good("R5 R6 R7"); else expect_bad();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule